// File: doc/BRIEF.md
# IPv4 Header Fast-Path Classifier and Rewriter

This block receives one IPv4 header of five 32-bit words (no options) over a valid/ready stream. It decides whether the packet may take the fast forwarding path. On the fast path it returns the header with the time-to-live reduced by one and the header checksum adjusted to match. Any header that is malformed, carries options, would need fragmentation on the egress link, or goes to a multicast group is marked for slow-path handling and returned untouched. The header checksum is never checked. It is only adjusted, so a header that arrived with a good checksum leaves with a good one, and a bad checksum stays bad for the end host to catch. The destination address is returned with every verdict for use by an external route lookup.

Control is a three-state machine. `S_HEAD` waits for word 0. `S_BODY` takes words 1 to 4. `S_REPORT` holds the verdict for one cycle. The transitions are:
- `HEAD_TO_BODY` when word 0 is accepted.
- `BODY_TO_REPORT` when word 4 is accepted.
- `REPORT_TO_HEAD`, which is unconditional.

The verdict and header register on the edge that accepts word 4 and are valid during the following cycle.

Top module: `ipfp_header_engine`

## Requirements
- R1: After reset, `res_valid`, `res_fast` and `res_slow` are 0 and `in_ready` is 1.
- R2: A word is taken only on an edge where `in_valid` and `in_ready` are both 1. Words arrive in order 0 to 4. `in_ready` is 0 exactly in the cycle where `res_valid` is 1.
- R3: `res_valid` is 1 for exactly one cycle: the cycle after the edge that accepts word 4.
- R4: A header is slow-path if any of these holds (bit 0 is the least significant bit of a word):
  - version (word 0 bits 31:28) is not 4;
  - header length in 32-bit words (word 0 bits 27:24) is below 5;
  - total length (word 0 bits 15:0) is below 20;
  - time-to-live (word 2 bits 31:24) is 0 or 1.
- R5: A header length above 5 (options present) makes the header slow-path.
- R6: A total length greater than `mtu_bytes` makes the header slow-path. A total length equal to `mtu_bytes` does not.
- R7: A destination (word 4) whose top four bits are 1110 makes the header slow-path.
- R8: With `res_valid` high, exactly one of `res_fast` and `res_slow` is 1. `res_fast` is 1 only when none of the conditions of R4 to R7 holds. Both are 0 when `res_valid` is 0.
- R9: On the fast path, output word 2 carries time-to-live minus one in bits 31:24. Bits 23:16 are unchanged. Bits 15:0 carry the input checksum plus 0x0100 in ones'-complement arithmetic, with the carry out of bit 15 added back in. All other words are unchanged.
- R10: On the slow path, all five output words equal the input words.
- R11: With `res_valid` high, `res_dst` equals input word 4.
- R12: The incoming checksum does not affect the verdict. A header with a wrong checksum but otherwise valid is fast-path, and its checksum is adjusted per R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mtu_bytes | input | 16 | Egress link MTU in bytes |
| in_valid | input | 1 | Header word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 32 | Header word, word 0 first |
| res_valid | output | 1 | Verdict and header valid this cycle |
| res_fast | output | 1 | Fast-path verdict |
| res_slow | output | 1 | Slow-path verdict |
| res_dst | output | 32 | Destination address for route lookup |
| res_hdr | output | 160 | Output header, word k in bits 32k+31:32k |

## Verification
The bench targets the edges of each threshold:
- A time-to-live of 1 against 2. An off-by-one here would forward a packet that must expire, or send a live one to the slow path.
- A total length of 19 against 20, and lengths equal to and one above the MTU. A wrong comparison would fragment silently or divert legal traffic.
- Destinations just inside and just outside the multicast range. These catch a decoder that looks at the wrong bits.

Checksums of 0xFF00 and 0xFFFF exercise the end-around carry; an adder that drops it produces a checksum off by one that receivers would reject. Back-to-back headers with the next word held during the report cycle would expose a block that takes a word while its verdict is out, which would shift every later header by one word.

// File: rtl/ipfp_pkg.sv
package ipfp_pkg;
    localparam int WORD_W      = 32;
    localparam int HDR_WORDS   = 5;
    localparam int STORE_WORDS = HDR_WORDS - 1;
    localparam int IDX_W       = $clog2(HDR_WORDS);
    localparam int HDR_W       = HDR_WORDS * WORD_W;

    localparam logic [3:0]  IPV4_VERSION  = 4'd4;
    localparam logic [3:0]  BASE_IHL      = 4'd5;
    localparam logic [3:0]  GROUP_NIBBLE  = 4'hE;
    localparam logic [15:0] MIN_TOTAL_LEN = 16'd20;
    localparam logic [7:0]  MIN_LIVE_TTL  = 8'd2;
    localparam logic [15:0] TTL_CSUM_STEP = 16'h0100;

    typedef enum logic [1:0] {
        S_HEAD   = 2'd0,
        S_BODY   = 2'd1,
        S_REPORT = 2'd2
    } phase_t;
endpackage

// File: rtl/ipfp_word_store.sv
module ipfp_word_store
    import ipfp_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int NWORD = HDR_WORDS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          take,
    input  logic [W-1:0]                  word_in,
    output logic                          at_last,
    output logic [(NWORD-1)*W-1:0]        kept
);
    localparam int NKEEP = NWORD - 1;
    localparam int CW    = $clog2(NWORD);
    localparam logic [CW-1:0] LAST_IDX = CW'(NWORD - 1);

    logic [CW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

    assign at_last = (idx_q == LAST_IDX);

    for (genvar k = 0; k < NKEEP; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                kept[k*W +: W] <= '0;
            end else if (take && idx_q == CW'(k)) begin
                kept[k*W +: W] <= word_in;
            end
        end
    end
endmodule

// File: rtl/ipfp_classify.sv
module ipfp_classify
    import ipfp_pkg::*;
#(
    parameter int MTU_W = 16
) (
    input  logic [3:0]       version,
    input  logic [3:0]       ihl,
    input  logic [15:0]      total_len,
    input  logic [7:0]       ttl,
    input  logic [3:0]       dst_top,
    input  logic [MTU_W-1:0] mtu,
    output logic             fast
);
    localparam int CMP_W = (MTU_W > 16) ? MTU_W + 1 : 17;

    logic malformed, has_options, too_big, is_group;

    always_comb begin
        malformed   = (version != IPV4_VERSION) || (ihl < BASE_IHL) ||
                      (total_len < MIN_TOTAL_LEN) || (ttl < MIN_LIVE_TTL);
        has_options = (ihl > BASE_IHL);
        too_big     = CMP_W'(total_len) > CMP_W'(mtu);
        is_group    = (dst_top == GROUP_NIBBLE);
        fast        = !(malformed || has_options || too_big || is_group);
    end
endmodule

// File: rtl/ipfp_csum_bump.sv
module ipfp_csum_bump
    import ipfp_pkg::*;
(
    input  logic [15:0] csum_in,
    output logic [15:0] csum_out
);
    logic [16:0] wide;

    always_comb begin
        wide     = {1'b0, csum_in} + {1'b0, TTL_CSUM_STEP};
        csum_out = wide[15:0] + {15'd0, wide[16]};
    end
endmodule

// File: rtl/ipfp_header_engine.sv
module ipfp_header_engine
    import ipfp_pkg::*;
#(
    parameter int MTU_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MTU_W-1:0]     mtu_bytes,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [WORD_W-1:0]    in_word,
    output logic                 res_valid,
    output logic                 res_fast,
    output logic                 res_slow,
    output logic [WORD_W-1:0]    res_dst,
    output logic [HDR_W-1:0]     res_hdr
);
    localparam int TTL_WORD = 2;
    localparam int TTL_LO   = TTL_WORD * WORD_W;

    phase_t state_q, state_d;
    logic   take, at_last, fast;
    logic [STORE_WORDS*WORD_W-1:0] kept;
    logic [HDR_W-1:0]  hdr_in, hdr_new;
    logic [15:0]       csum_new;
    logic [WORD_W-1:0] w0, w2;

    assign in_ready = (state_q != S_REPORT);
    assign take     = in_valid && in_ready;

    ipfp_word_store #(.W(WORD_W), .NWORD(HDR_WORDS)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .word_in (in_word),
        .at_last (at_last),
        .kept    (kept)
    );

    assign hdr_in = {in_word, kept};
    assign w0     = hdr_in[0 +: WORD_W];
    assign w2     = hdr_in[TTL_LO +: WORD_W];

    ipfp_classify #(.MTU_W(MTU_W)) class_i (
        .version   (w0[31:28]),
        .ihl       (w0[27:24]),
        .total_len (w0[15:0]),
        .ttl       (w2[31:24]),
        .dst_top   (in_word[31:28]),
        .mtu       (mtu_bytes),
        .fast      (fast)
    );

    ipfp_csum_bump bump_i (
        .csum_in  (w2[15:0]),
        .csum_out (csum_new)
    );

    always_comb begin
        hdr_new = hdr_in;
        if (fast) begin
            hdr_new[TTL_LO +: WORD_W] = {w2[31:24] - 8'd1, w2[23:16], csum_new};
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_HEAD;
        else        state_q <= state_d;
    end

    // Transitions: HEAD_TO_BODY, BODY_TO_REPORT, REPORT_TO_HEAD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HEAD:   if (take)            state_d = S_BODY;
            S_BODY:   if (take && at_last) state_d = S_REPORT;
            S_REPORT:                      state_d = S_HEAD;
            default:                       state_d = S_HEAD;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_fast  <= 1'b0;
            res_slow  <= 1'b0;
            res_dst   <= '0;
            res_hdr   <= '0;
        end else if (state_q == S_BODY && take && at_last) begin
            res_valid <= 1'b1;
            res_fast  <= fast;
            res_slow  <= !fast;
            res_dst   <= in_word;
            res_hdr   <= hdr_new;
        end else begin
            res_valid <= 1'b0;
            res_fast  <= 1'b0;
            res_slow  <= 1'b0;
        end
    end
endmodule

// File: rtl/ipfp_checker.sv
module ipfp_checker
    import ipfp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              res_valid,
    input logic              res_fast,
    input logic              res_slow,
    input logic [WORD_W-1:0] res_dst,
    input logic [HDR_W-1:0]  res_hdr
);
    AST_RDY_LOW_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !in_ready);                                     // R2
    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);                                    // R3
    AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_fast != res_slow));                        // R8
    AST_IDLE_NO_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_fast && !res_slow));                     // R8
    AST_GROUP_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_dst[31:28] == 4'hE) |-> res_slow);          // R7
    AST_FAST_BASE_IHL: assert property (@(posedge clk) disable iff (!rst_n)
        res_fast |-> (res_hdr[27:24] == 4'd5));                       // R5
    AST_FAST_TTL_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        res_fast |-> (res_hdr[95:88] != 8'd0));                       // R4
    AST_DST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_dst == res_hdr[159:128]));                 // R11
endmodule

bind ipfp_header_engine ipfp_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .res_valid (res_valid),
    .res_fast  (res_fast),
    .res_slow  (res_slow),
    .res_dst   (res_dst),
    .res_hdr   (res_hdr)
);

// File: tb/ipfp_header_engine_tb.sv
module ipfp_header_engine_tb_top;
    typedef logic [4:0][31:0] hdr5_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  mtu_bytes = 16'd1500;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_word = '0;
    logic         res_valid, res_fast, res_slow;
    logic [31:0]  res_dst;
    logic [159:0] res_hdr;

    int n_checks = 0;
    int n_fails  = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    ipfp_header_engine dut_i (
        .clk(clk), .rst_n(rst_n), .mtu_bytes(mtu_bytes),
        .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
        .res_valid(res_valid), .res_fast(res_fast), .res_slow(res_slow),
        .res_dst(res_dst), .res_hdr(res_hdr)
    );

    task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, cur_tag, act, exp);
        end
    endtask

    function automatic hdr5_t mk(input int ver, input int ihl, input int tot,
                                 input int ttl, input int cs, input logic [31:0] dst);
        hdr5_t h;
        h[0] = {ver[3:0], ihl[3:0], 8'h00, tot[15:0]};
        h[1] = 32'h1c46_4000;
        h[2] = {ttl[7:0], 8'd17, cs[15:0]};
        h[3] = 32'h0a00_0001;
        h[4] = dst;
        return h;
    endfunction

    // Behavioural reference
    bit          exp_v = 0, exp_fast = 0;
    logic [159:0] exp_hdr = '0;
    string       exp_why = "R8";
    hdr5_t       cap;
    int          cnt = 0;

    task automatic predict(input hdr5_t h, input int mtu);
        int ver, ihl, tot, ttl, s;
        bit bad, opt, big, grp;
        ver = h[0][31:28]; ihl = h[0][27:24]; tot = h[0][15:0]; ttl = h[2][31:24];
        bad = (ver != 4) || (ihl < 5) || (tot < 20) || (ttl < 2);
        opt = ihl > 5;
        big = tot > mtu;
        grp = h[4][31:28] == 4'b1110;
        exp_fast = !(bad || opt || big || grp);
        exp_why  = bad ? "R4" : opt ? "R5" : big ? "R6" : grp ? "R7" : "R8";
        exp_hdr  = h;
        if (exp_fast) begin
            s = int'(h[2][15:0]) + 256;
            if (s > 65535) s = s - 65535;
            exp_hdr[95:64] = {8'(ttl - 1), h[2][23:16], 16'(s)};
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            check(res_valid === 1'b0 && res_fast === 1'b0 && res_slow === 1'b0, "R1",
                  {res_valid, res_fast, res_slow}, 0);
            cnt = 0; exp_v = 0;
        end else begin
            check(res_valid === exp_v, "R3", res_valid, exp_v);
            check(in_ready === !exp_v, "R2", in_ready, !exp_v);
            if (exp_v) begin
                check(res_fast === exp_fast && res_slow === !exp_fast, exp_why,
                      {res_fast, res_slow}, {exp_fast, !exp_fast});
                check(res_hdr === exp_hdr, exp_fast ? "R9" : "R10", res_hdr, exp_hdr);
                check(res_dst === exp_hdr[159:128], "R11", res_dst, exp_hdr[159:128]);
            end
            exp_v = 0;
            if (in_valid && in_ready) begin
                cap[cnt] = in_word;
                cnt++;
                if (cnt == 5) begin
                    predict(cap, int'(mtu_bytes));
                    exp_v = 1;
                    cnt = 0;
                end
            end
        end
    end

    task automatic send_hdr(input hdr5_t h, input int gap, input string tag);
        cur_tag = tag;
        for (int k = 0; k < 5; k++) begin
            bit rdy;
            in_valid = 1'b1;
            in_word  = h[k];
            do begin
                @(negedge clk);
                rdy = in_ready;
                @(posedge clk);
                #1;
            end while (!rdy);
        end
        if (gap > 0) begin
            in_valid = 1'b0;
            repeat (gap) @(posedge clk);
            #1;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1 && res_valid === 1'b0, "R1", {in_ready, res_valid}, 2'b10);
        @(posedge clk); #1;

        send_hdr(mk(4, 5, 600, 64, 16'hb1e6, 32'h0a01_0203), 2, "R8 plain fast");
        send_hdr(mk(4, 5, 600, 2, 16'h1234, 32'h0a01_0203), 1, "R4 ttl 2 fast");
        send_hdr(mk(4, 5, 600, 1, 16'h1234, 32'h0a01_0203), 1, "R4 ttl 1");
        send_hdr(mk(4, 5, 600, 0, 16'h1234, 32'h0a01_0203), 1, "R4 ttl 0");
        send_hdr(mk(6, 5, 600, 64, 16'h1234, 32'h0a01_0203), 1, "R4 version");
        send_hdr(mk(4, 4, 600, 64, 16'h1234, 32'h0a01_0203), 1, "R4 ihl 4");
        send_hdr(mk(4, 5, 19, 64, 16'h1234, 32'h0a01_0203), 1, "R4 len 19");
        send_hdr(mk(4, 5, 20, 64, 16'h1234, 32'h0a01_0203), 1, "R4 len 20 fast");
        send_hdr(mk(4, 6, 600, 64, 16'h1234, 32'h0a01_0203), 1, "R5 options");
        send_hdr(mk(4, 5, 1500, 64, 16'h1234, 32'h0a01_0203), 1, "R6 len eq mtu");
        send_hdr(mk(4, 5, 1501, 64, 16'h1234, 32'h0a01_0203), 1, "R6 len over mtu");
        mtu_bytes = 16'd576;
        send_hdr(mk(4, 5, 577, 64, 16'h1234, 32'h0a01_0203), 1, "R6 small mtu");
        mtu_bytes = 16'd1500;
        send_hdr(mk(4, 5, 600, 64, 16'h1234, 32'he000_0001), 1, "R7 group low");
        send_hdr(mk(4, 5, 600, 64, 16'h1234, 32'hefff_fffe), 1, "R7 group high");
        send_hdr(mk(4, 5, 600, 64, 16'h1234, 32'hdfff_ffff), 1, "R7 below group");
        send_hdr(mk(4, 5, 600, 64, 16'h1234, 32'hf000_0000), 1, "R7 above group");
        send_hdr(mk(4, 5, 600, 64, 16'hff00, 32'h0a01_0203), 1, "R9 carry ff00");
        send_hdr(mk(4, 5, 600, 64, 16'hffff, 32'h0a01_0203), 1, "R9 carry ffff");
        send_hdr(mk(4, 5, 600, 64, 16'hfeff, 32'h0a01_0203), 1, "R9 edge feff");
        send_hdr(mk(4, 5, 600, 64, 16'hdead, 32'h0a01_0203), 1, "R12 bad checksum");
        // Back-to-back headers, next word held during the report cycle (R2)
        send_hdr(mk(4, 5, 100, 9, 16'h0001, 32'h0102_0304), 0, "R2 burst a");
        send_hdr(mk(4, 5, 100, 1, 16'h0002, 32'h0506_0708), 0, "R2 burst b");
        send_hdr(mk(4, 5, 100, 33, 16'h0003, 32'h090a_0b0c), 3, "R2 burst c");
        repeat (3) @(posedge clk);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule